// File: doc/BRIEF.md
# Interrupt Pending and Status Registers

This block keeps the pending-request and status state of a small embedded interrupt controller and presents it as two read-only 16-bit words on a combinational register-read port. Seven internal sources raise single-cycle request pulses: two serial ports, two DMA channels (which share their positions with interrupt lines 5 and 6) and three timers. Each pulse sets a pending bit. The bit stays set until the internal acknowledge for that same source clears it. Five external interrupt lines are not latched. They pass through a synchronizer and are shown at their current level.

A halt flag is set when a non-maskable interrupt is taken and cleared when an interrupt return happens. While the flag is set, the `dma_halt` output is asserted to stop all DMA activity. A mode input selects master or slave reset behaviour for the status word. Priority resolution, masking, vector generation and the DMA engines are outside this block.

Top module: `irq_state_regs`

## Requirements
- R1: A one-cycle pulse on `src_req[i]` sets pending bit i at the next clock edge. The bit then holds with no further pulse. Source index map: 0 serial port 0, 1 serial port 1, 2 DMA0/line 5, 3 DMA1/line 6, 4..6 timers 0..2.
- R2: A pulse on `src_ack[i]` clears pending bit i at the next edge. An acknowledge for a source that is not pending changes nothing.
- R3: When `src_req[i]` and `src_ack[i]` are high in the same cycle, pending bit i ends set.
- R4: Reading address 0x2E returns the request word, with this layout:
  - bit 10: serial port 0
  - bit 9: serial port 1
  - bit 3: DMA1/line 6
  - bit 2: DMA0/line 5
  - bits 15..11 and bit 1: read as 0
- R5: Request word bit 0 is the OR of the three timer pending bits. In the status word at address 0x30, bits 2..0 are the pending bits of timers 2..0 and bits 14..3 read as 0.
- R6: Request word bits 8..4 show external lines 4..0 (`ext_irq[4:0]`), unlatched. A level change on a line first appears in a read two clock edges after it is applied, and goes away in the same way.
- R7: An `nmi_enter` pulse sets the halt flag at the next edge. An `irq_return` pulse without `nmi_enter` clears it. `dma_halt` and status bit 15 both equal the flag.
- R8: If `nmi_enter` and `irq_return` coincide, the halt flag ends set.
- R9: After reset, with default parameters and in either mode, both words read 0000h and `dma_halt` is 0.
- R10: A read of any address other than 0x2E or 0x30 returns 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = master, 0 = slave; selects the status reset value |
| src_req | input | 7 | Internal request pulses, one per source |
| src_ack | input | 7 | Internal acknowledge pulses, one per source |
| ext_irq | input | 5 | Asynchronous external interrupt lines 4..0 |
| nmi_enter | input | 1 | Pulse when a non-maskable interrupt is taken |
| irq_return | input | 1 | Pulse when an interrupt return happens |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` and state |
| dma_halt | output | 1 | Stop request to all DMA engines |

## Verification
Every result driven by a latched bit (request pending bits, acknowledge clears and the halt flag) is due one clock edge after its pulse. Every external line level is due two edges after it changes. The read path adds no cycle. Inputs are changed on the falling edge and reads are sampled on the next falling edge, so a one-edge result is checked exactly one edge later. For the external lines, the bench checks that the old value is still shown after the first edge and that the new value appears after the second. The same two-step check is made when a line falls.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
   // internal source indices
   localparam int SRC_SP0  = 0;
   localparam int SRC_SP1  = 1;
   localparam int SRC_DMA0 = 2;
   localparam int SRC_DMA1 = 3;
   localparam int SRC_TMR0 = 4;
   localparam int NUM_TMR  = 3;
   localparam int NUM_SRC  = SRC_TMR0 + NUM_TMR;
   localparam int NUM_EXT  = 5;
   localparam int WORD_W   = 16;

   // field positions decoded by software
   localparam int RQ_SP0    = 10;
   localparam int RQ_SP1    = 9;
   localparam int RQ_EXT_LO = 4;
   localparam int RQ_DMA1   = 3;
   localparam int RQ_DMA0   = 2;
   localparam int RQ_TMR    = 0;
   localparam int ST_HALT   = 15;
   localparam int ST_TMR_LO = 0;

   typedef logic [WORD_W-1:0] reg_word_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("irq_sync width must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= pin;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

   // R6: level seen at the output is the pin two edges earlier
   generate
      if (STAGES == 2) begin : g_chk2
         a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(pin, 2)));
      end
   endgenerate
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rst_val,
   input  logic [N-1:0] req,
   input  logic [N-1:0] ack,
   output logic [N-1:0] pend
);
   generate
      if (N < 1) begin : g_bad_n
         $error("irq_pend_bank needs at least one source");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)      pend[i] <= rst_val[i];
            else if (req[i]) pend[i] <= 1'b1;
            else if (ack[i]) pend[i] <= 1'b0;
         end

         // R1: a request sets the bit
         a_r1_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
            req[i] |=> pend[i]);
         // R1: with no event the bit holds
         a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!req[i] && !ack[i]) |=> $stable(pend[i]));
         // R2: an acknowledge alone clears the bit
         a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && !req[i]) |=> !pend[i]);
         // R3: request wins over a coincident acknowledge
         a_r3_req_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && req[i]) |=> pend[i]);
      end
   endgenerate
endmodule

// File: rtl/irq_halt_flag.sv
module irq_halt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_val,
   input  logic nmi_enter,
   input  logic irq_return,
   output logic halt
);
   always_ff @(posedge clk) begin
      if (!rst_n)          halt <= rst_val;
      else if (nmi_enter)  halt <= 1'b1;
      else if (irq_return) halt <= 1'b0;
   end

   // R7: entry sets, lone return clears
   a_r7_nmi_sets: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_enter |=> halt);
   a_r7_ret_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_return && !nmi_enter) |=> !halt);
   // R8: coincident entry and return leave it set
   a_r8_coincide: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_return && nmi_enter) |=> halt);
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_return && !nmi_enter) |=> $stable(halt));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_regs_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter [ADDR_W-1:0] REQ_OFS  = 8'h2E,
   parameter [ADDR_W-1:0] STAT_OFS = 8'h30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_EXT-1:0] ext,
   input  logic               halt,
   input  logic [ADDR_W-1:0]  rd_addr,
   output reg_word_t          rd_data
);
   generate
      if (REQ_OFS == STAT_OFS) begin : g_bad_ofs
         $error("request and status offsets must differ");
      end
   endgenerate

   reg_word_t req_word, stat_word;

   always_comb begin
      req_word = '0;
      req_word[RQ_SP0]  = pend[SRC_SP0];
      req_word[RQ_SP1]  = pend[SRC_SP1];
      req_word[RQ_DMA1] = pend[SRC_DMA1];
      req_word[RQ_DMA0] = pend[SRC_DMA0];
      req_word[RQ_TMR]  = |pend[SRC_TMR0 +: NUM_TMR];
      req_word[RQ_EXT_LO +: NUM_EXT] = ext;

      stat_word = '0;
      stat_word[ST_HALT] = halt;
      stat_word[ST_TMR_LO +: NUM_TMR] = pend[SRC_TMR0 +: NUM_TMR];
   end

   always_comb begin
      if (rd_addr == REQ_OFS)       rd_data = req_word;
      else if (rd_addr == STAT_OFS) rd_data = stat_word;
      else                          rd_data = '0;
   end

   // R4: reserved request bits read zero
   a_r4_req_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == REQ_OFS) |-> (rd_data[15:11] == 5'd0 && rd_data[1] == 1'b0));
   // R5: reserved status bits read zero
   a_r5_stat_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == STAT_OFS) |-> (rd_data[14:3] == 12'd0));
   // R10: unmapped addresses read zero
   a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr != REQ_OFS && rd_addr != STAT_OFS) |-> (rd_data == '0));
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
   import irq_regs_pkg::*;
#(
   parameter int          ADDR_W          = 8,
   parameter [ADDR_W-1:0] REQ_OFS         = 8'h2E,
   parameter [ADDR_W-1:0] STAT_OFS        = 8'h30,
   parameter int          SYNC_STAGES     = 2,
   parameter [15:0]       MASTER_STAT_RST = 16'h0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               master_mode,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] src_ack,
   input  logic [NUM_EXT-1:0] ext_irq,
   input  logic               nmi_enter,
   input  logic               irq_return,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [15:0]        rd_data,
   output logic               dma_halt
);
   generate
      if (MASTER_STAT_RST[14:3] != 12'd0) begin : g_bad_rst
         $error("master reset value must keep reserved status bits zero");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend, pend_rst;
   logic [NUM_EXT-1:0] ext_s;
   logic               halt, halt_rst;

   // slave mode resets to zero; master mode takes the parameter
   always_comb begin
      pend_rst = '0;
      pend_rst[SRC_TMR0 +: NUM_TMR] = master_mode ? MASTER_STAT_RST[ST_TMR_LO +: NUM_TMR]
                                                  : '0;
      halt_rst = master_mode & MASTER_STAT_RST[ST_HALT];
   end

   irq_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_irq), .q(ext_s));

   irq_pend_bank #(.N(NUM_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .rst_val(pend_rst),
      .req(src_req), .ack(src_ack), .pend(pend));

   irq_halt_flag u_halt (
      .clk(clk), .rst_n(rst_n), .rst_val(halt_rst),
      .nmi_enter(nmi_enter), .irq_return(irq_return), .halt(halt));

   irq_read_mux #(.ADDR_W(ADDR_W), .REQ_OFS(REQ_OFS), .STAT_OFS(STAT_OFS)) u_mux (
      .clk(clk), .rst_n(rst_n), .pend(pend), .ext(ext_s), .halt(halt),
      .rd_addr(rd_addr), .rd_data(rd_data));

   assign dma_halt = halt;

   // R9: first cycle after a slave-mode reset everything is clear
   a_r9_slave_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && !$past(master_mode)) |-> (pend == '0 && !halt));
endmodule

// File: tb/tb_irq_state_regs.sv
module tb_irq_state_regs;
   localparam logic [7:0] A_REQ  = 8'h2E;
   localparam logic [7:0] A_STAT = 8'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_mode = 1'b0;
   logic [6:0]  src_req = '0, src_ack = '0;
   logic [4:0]  ext_irq = '0;
   logic        nmi_enter = 1'b0, irq_return = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        dma_halt;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   irq_state_regs dut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .src_req(src_req), .src_ack(src_ack), .ext_irq(ext_irq),
      .nmi_enter(nmi_enter), .irq_return(irq_return),
      .rd_addr(rd_addr), .rd_data(rd_data), .dma_halt(dma_halt));

   // {req, ack, expected request word, expected status word}
   localparam int NV = 9;
   localparam logic [45:0] VEC [NV] = '{
      {7'b0000001, 7'b0000000, 16'h0400, 16'h0000},
      {7'b0001010, 7'b0000000, 16'h0608, 16'h0000},
      {7'b1010000, 7'b0000000, 16'h0609, 16'h0005},
      {7'b0000000, 7'b0000001, 16'h0209, 16'h0005},
      {7'b0000000, 7'b0010000, 16'h0209, 16'h0004},
      {7'b0000100, 7'b0000100, 16'h020D, 16'h0004},
      {7'b0000000, 7'b1001110, 16'h0000, 16'h0000},
      {7'b0100000, 7'b0000010, 16'h0001, 16'h0002},
      {7'b0000000, 7'b0100000, 16'h0000, 16'h0000}
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
      rd_addr = a;
      #1;
      chk(rd_data, exp, tag);
   endtask

   initial begin
      #(20 * 5000);
      bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      step(); step(); step();
      rst_n = 1'b1;
      step();
      // R9: slave-mode reset state
      rd(A_REQ,  16'h0000, "R9 slave reset request word");
      rd(A_STAT, 16'h0000, "R9 slave reset status word");
      chk({15'd0, dma_halt}, 16'h0000, "R9 slave reset dma_halt");

      // table walk: R1 R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         src_req = VEC[v][45:39];
         src_ack = VEC[v][38:32];
         step();
         src_req = '0;
         src_ack = '0;
         rd(A_REQ,  VEC[v][31:16], $sformatf("R1/R2/R3/R4 vector %0d request", v));
         rd(A_STAT, VEC[v][15:0],  $sformatf("R5 vector %0d status", v));
      end

      // R1: a bit holds over idle cycles
      src_req = 7'b0000010;
      step();
      src_req = '0;
      step(); step(); step();
      rd(A_REQ, 16'h0200, "R1 hold after idle cycles");
      src_ack = 7'b0000010;
      step();
      src_ack = '0;
      rd(A_REQ, 16'h0000, "R2 clear after hold");

      // R6: two-edge external latency, rise and fall
      ext_irq = 5'b10110;
      step();
      rd(A_REQ, 16'h0000, "R6 external not yet visible after one edge");
      step();
      rd(A_REQ, 16'h0160, "R6 external visible after two edges");
      ext_irq = 5'b00001;
      step();
      rd(A_REQ, 16'h0160, "R6 old level held one edge");
      step();
      rd(A_REQ, 16'h0010, "R6 unlatched new level");
      ext_irq = 5'b00000;
      step(); step();
      rd(A_REQ, 16'h0000, "R6 external cleared");

      // R7: halt flag set and clear
      nmi_enter = 1'b1;
      step();
      nmi_enter = 1'b0;
      chk({15'd0, dma_halt}, 16'h0001, "R7 dma_halt after entry");
      rd(A_STAT, 16'h8000, "R7 status halt bit");
      src_req = 7'b0100000;
      step();
      src_req = '0;
      rd(A_STAT, 16'h8002, "R7/R5 halt with timer 1");
      irq_return = 1'b1;
      step();
      irq_return = 1'b0;
      chk({15'd0, dma_halt}, 16'h0000, "R7 dma_halt after return");
      rd(A_STAT, 16'h0002, "R7 status after return");
      irq_return = 1'b1;
      step();
      irq_return = 1'b0;
      chk({15'd0, dma_halt}, 16'h0000, "R7 return while clear");

      // R8: coincident entry and return
      nmi_enter = 1'b1;
      irq_return = 1'b1;
      step();
      nmi_enter = 1'b0;
      irq_return = 1'b0;
      chk({15'd0, dma_halt}, 16'h0001, "R8 coincident leaves set");

      // R10: unmapped addresses
      rd(8'h00, 16'h0000, "R10 address 00");
      rd(8'h2F, 16'h0000, "R10 address 2F");
      rd(8'hFF, 16'h0000, "R10 address FF");

      // R9: master-mode reset clears everything set above
      master_mode = 1'b1;
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
      rd(A_REQ,  16'h0000, "R9 master reset request word");
      rd(A_STAT, 16'h0000, "R9 master reset status word");
      chk({15'd0, dma_halt}, 16'h0000, "R9 master reset dma_halt");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule